// File: doc/BRIEF.md
# Dual-Channel Thermal Monitor Controller

This block watches two on-die temperature sensors without help from software. A period timer starts a conversion round on its own. In each round, every enabled channel is converted in turn, channel 0 first, through a start/done handshake with an external converter. Each 12-bit result is stored and compared against three thresholds for that channel: a high alarm, a shutdown level and a low alarm. A larger code means a hotter die.

A high alarm needs a programmable number of consecutive readings at or above its threshold, and so does a shutdown. Each has its own debounce count. While any channel's latest reading is at or above its high threshold, a second, separately programmed period sets the pace of the rounds. Events are collected in a write-1-to-clear pending register. The pending register drives a maskable interrupt and two shutdown outputs. One shutdown output goes to a reset controller. The other goes to a pin whose active level can be programmed.

Software reads and writes the registers through a simple word-addressed port with one cycle of read latency. Turning code into temperature is left to software.

Top module: `thermo_watch`

## Requirements
- R1: After reset the register port returns 1875 for both period registers, 4 for both debounce counts, 0xFFF for every high and shutdown threshold and 0 for every low threshold. After reset irq and shut_rst are 0, shut_pin is 1 and adc_start is 0.
- R2: While control bit 0 (auto enable) is 0, no conversion is started, whatever the source enables and periods are, and all period and debounce counters are held cleared.
- R3: With auto enabled, a round starts once the selected period has elapsed. adc_start is a one-cycle pulse, and only channels whose control bit 4+n is set are converted. Within a round the order is channel 0 then channel 1.
- R4: A channel's data register (word 3+n) changes only when adc_done ends a conversion of that channel. The other channel's data stays as it was.
- R5: Pending bit n (high alarm) is set on the sample that completes the count of consecutive samples with code >= high threshold (word 5+n) given by word 13. Any sample below the threshold restarts the count.
- R6: Pending bit 4+n (shutdown) is set in the same way against the shutdown threshold (word 7+n) with the count in word 14. Once set, it stays set until a 1 is written to it in the pending register (word 2), even after the readings fall.
- R7: Pending bit 12+n (low alarm) is set by any sample with code <= low threshold (word 9+n), and only while control bit 12+n is set.
- R8: Pending bit 16 is set after every completed conversion.
- R9: Writing 1 to a pending bit clears it. A hardware set in the same cycle wins. irq is the OR of pending bits 0..1, 12..13 and 16, each ANDed with the same bit of the interrupt enable register (word 1).
- R10: shut_rst is high while any latched shutdown bit 4+n has enable bit 8+n set. The pin route uses enable bit 4+n. shut_pin is active high when control bit 8 is 1 and active low when it is 0.
- R11: While any channel's latest sample is at or above its high threshold, rounds are spaced by the hot period (word 12) instead of the normal period (word 11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, one cycle after the address |
| adc_start | output | 1 | One-cycle conversion start pulse |
| adc_sel | output | 1 | Channel being converted |
| adc_done | input | 1 | Conversion finished strobe |
| adc_code | input | 12 | Conversion result, valid with adc_done |
| irq | output | 1 | Interrupt request |
| shut_rst | output | 1 | Shutdown request to the reset controller |
| shut_pin | output | 1 | Shutdown pin with programmable polarity |

## Verification
The bench feeds codes that sit exactly on each threshold, because a design that used a strict comparison would miss the alarm there. It breaks a run of hot readings with one cool reading, which catches a debounce counter that is never cleared or that fires one sample early or late. It lets the readings drop after a shutdown, and a shutdown that is not latched would release at that point. It also measures the spacing between rounds while the die is hot and after it cools, so a design that always used one period fails, as does one that starts conversions with auto mode off, swaps the channel order or writes the result into the wrong data register.

// File: rtl/thermo_pkg.sv
package thermo_pkg;

  // control bit positions
  localparam int CB_AUTO = 0;
  localparam int CB_SRC  = 4;
  localparam int CB_POL  = 8;
  localparam int CB_LO   = 12;

  // enable / pending bit positions
  localparam int PB_HI   = 0;
  localparam int PB_SHUT = 4;
  localparam int PB_RST  = 8;
  localparam int PB_LO   = 12;
  localparam int PB_EOC  = 16;

  typedef enum logic {SQ_WAIT = 1'b0, SQ_BUSY = 1'b1} seq_state_e;

  function automatic logic [31:0] ctrl_mask(input int n);
    logic [31:0] m;
    m = '0;
    m[CB_AUTO] = 1'b1;
    m[CB_POL]  = 1'b1;
    for (int i = 0; i < n; i++) begin
      m[CB_SRC + i] = 1'b1;
      m[CB_LO + i]  = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [31:0] ie_mask(input int n);
    logic [31:0] m;
    m = '0;
    m[PB_EOC] = 1'b1;
    for (int i = 0; i < n; i++) begin
      m[PB_HI + i]   = 1'b1;
      m[PB_SHUT + i] = 1'b1;
      m[PB_RST + i]  = 1'b1;
      m[PB_LO + i]   = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [31:0] irq_mask(input int n);
    logic [31:0] m;
    m = '0;
    m[PB_EOC] = 1'b1;
    for (int i = 0; i < n; i++) begin
      m[PB_HI + i] = 1'b1;
      m[PB_LO + i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/thermo_seq.sv
module thermo_seq
  import thermo_pkg::*;
#(
  parameter int NCH = 2,
  parameter int PW  = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           auto_en,
  input  logic [NCH-1:0] src_en,
  input  logic           hot_any,
  input  logic [PW-1:0]  per_norm,
  input  logic [PW-1:0]  per_hot,
  input  logic           adc_done,
  output logic           adc_start,
  output logic [CHW-1:0] adc_sel,
  output logic           samp_vld,
  output logic [CHW-1:0] samp_ch
);

  seq_state_e    st_q;
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] per_sel, lim;
  logic          first_ok, next_ok;
  logic [CHW-1:0] first_ch, next_ch;

  assign per_sel = hot_any ? per_hot : per_norm;
  assign lim     = (per_sel == '0) ? '0 : per_sel - 1'b1;

  // lowest enabled channel, and lowest enabled channel above the current one
  always_comb begin
    first_ok = 1'b0;
    first_ch = '0;
    next_ok  = 1'b0;
    next_ch  = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (src_en[i]) begin
        first_ok = 1'b1;
        first_ch = CHW'(i);
        if (i > int'(adc_sel)) begin
          next_ok = 1'b1;
          next_ch = CHW'(i);
        end
      end
    end
  end

  assign samp_vld = (st_q == SQ_BUSY) && adc_done && !adc_start && auto_en;
  assign samp_ch  = adc_sel;

  always_ff @(posedge clk) begin
    if (rst || !auto_en) begin
      st_q      <= SQ_WAIT;
      cnt_q     <= '0;
      adc_start <= 1'b0;
      adc_sel   <= '0;
    end else begin
      adc_start <= 1'b0;
      case (st_q)
        SQ_WAIT: begin
          if (cnt_q >= lim) begin
            cnt_q <= '0;
            if (first_ok) begin
              adc_sel   <= first_ch;
              adc_start <= 1'b1;
              st_q      <= SQ_BUSY;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SQ_BUSY: begin
          if (adc_done && !adc_start) begin
            if (next_ok) begin
              adc_sel   <= next_ch;
              adc_start <= 1'b1;
            end else begin
              st_q  <= SQ_WAIT;
              cnt_q <= '0;
            end
          end
        end
        default: st_q <= SQ_WAIT;
      endcase
    end
  end

endmodule

// File: rtl/thermo_chan.sv
module thermo_chan #(
  parameter int DW  = 12,
  parameter int DBW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           samp,
  input  logic [DW-1:0]  code,
  input  logic [DW-1:0]  hi_thr,
  input  logic [DW-1:0]  sh_thr,
  input  logic [DW-1:0]  lo_thr,
  input  logic           lo_en,
  input  logic [DBW-1:0] db_hi,
  input  logic [DBW-1:0] db_sh,
  output logic [DW-1:0]  data_q,
  output logic           hi_evt,
  output logic           sh_evt,
  output logic           lo_evt,
  output logic           hot
);

  localparam logic [DBW-1:0] CNT_MAX = '1;

  logic [DBW-1:0] hi_cnt, sh_cnt, hi_inc, sh_inc;
  logic           over_hi, over_sh;

  assign over_hi = code >= hi_thr;
  assign over_sh = code >= sh_thr;
  assign hi_inc  = (hi_cnt == CNT_MAX) ? hi_cnt : hi_cnt + 1'b1;
  assign sh_inc  = (sh_cnt == CNT_MAX) ? sh_cnt : sh_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)       data_q <= '0;
    else if (samp) data_q <= code;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hi_cnt <= '0;
      sh_cnt <= '0;
      hi_evt <= 1'b0;
      sh_evt <= 1'b0;
      lo_evt <= 1'b0;
      hot    <= 1'b0;
    end else begin
      hi_evt <= 1'b0;
      sh_evt <= 1'b0;
      lo_evt <= 1'b0;
      if (samp) begin
        hi_cnt <= over_hi ? hi_inc : '0;
        sh_cnt <= over_sh ? sh_inc : '0;
        hi_evt <= over_hi && (hi_inc >= db_hi);
        sh_evt <= over_sh && (sh_inc >= db_sh);
        lo_evt <= lo_en && (code <= lo_thr);
        hot    <= over_hi;
      end
    end
  end

endmodule

// File: rtl/thermo_watch.sv
module thermo_watch
  import thermo_pkg::*;
#(
  parameter int NCH = 2,
  parameter int DW  = 12,
  parameter int PW  = 32,
  parameter int DBW = 8,
  parameter int AW  = 4,
  parameter logic [PW-1:0]  PER_RST = 1875,
  parameter logic [DBW-1:0] DB_RST  = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic [AW-1:0]         reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  output logic                  adc_start,
  output logic [$clog2(NCH)-1:0] adc_sel,
  input  logic                  adc_done,
  input  logic [DW-1:0]         adc_code,
  output logic                  irq,
  output logic                  shut_rst,
  output logic                  shut_pin
);

  localparam int CHW     = $clog2(NCH);
  localparam int A_CTRL  = 0;
  localparam int A_IE    = 1;
  localparam int A_PD    = 2;
  localparam int A_DATA  = 3;
  localparam int A_HI    = A_DATA + NCH;
  localparam int A_SHUT  = A_HI + NCH;
  localparam int A_LO    = A_SHUT + NCH;
  localparam int A_PNORM = A_LO + NCH;
  localparam int A_PHOT  = A_PNORM + 1;
  localparam int A_DBHI  = A_PHOT + 1;
  localparam int A_DBSH  = A_DBHI + 1;
  localparam logic [31:0] CTRL_M = ctrl_mask(NCH);
  localparam logic [31:0] IE_M   = ie_mask(NCH);
  localparam logic [31:0] IRQ_M  = irq_mask(NCH);

  logic [31:0]    ctrl_q, ie_q, pd_q, pd_set, pd_clr, rd_mux;
  logic [DW-1:0]  hi_thr [NCH];
  logic [DW-1:0]  sh_thr [NCH];
  logic [DW-1:0]  lo_thr [NCH];
  logic [DW-1:0]  data_w [NCH];
  logic [PW-1:0]  per_norm, per_hot;
  logic [DBW-1:0] db_hi, db_sh;
  logic [NCH-1:0] hi_evt, sh_evt, lo_evt, hot;
  logic           samp_vld, eoc_evt;
  logic [CHW-1:0] samp_ch;
  logic           gpio_act;

  // ---------------- register writes ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      ie_q     <= '0;
      per_norm <= PER_RST;
      per_hot  <= PER_RST;
      db_hi    <= DB_RST;
      db_sh    <= DB_RST;
      for (int c = 0; c < NCH; c++) begin
        hi_thr[c] <= '1;
        sh_thr[c] <= '1;
        lo_thr[c] <= '0;
      end
    end else if (reg_wr) begin
      if (reg_addr == AW'(A_CTRL))  ctrl_q   <= reg_wdata & CTRL_M;
      if (reg_addr == AW'(A_IE))    ie_q     <= reg_wdata & IE_M;
      if (reg_addr == AW'(A_PNORM)) per_norm <= reg_wdata[PW-1:0];
      if (reg_addr == AW'(A_PHOT))  per_hot  <= reg_wdata[PW-1:0];
      if (reg_addr == AW'(A_DBHI))  db_hi    <= reg_wdata[DBW-1:0];
      if (reg_addr == AW'(A_DBSH))  db_sh    <= reg_wdata[DBW-1:0];
      for (int c = 0; c < NCH; c++) begin
        if (reg_addr == AW'(A_HI + c))   hi_thr[c] <= reg_wdata[DW-1:0];
        if (reg_addr == AW'(A_SHUT + c)) sh_thr[c] <= reg_wdata[DW-1:0];
        if (reg_addr == AW'(A_LO + c))   lo_thr[c] <= reg_wdata[DW-1:0];
      end
    end
  end

  // ---------------- read port ----------------
  always_comb begin
    rd_mux = '0;
    if (reg_addr == AW'(A_CTRL))  rd_mux = ctrl_q;
    if (reg_addr == AW'(A_IE))    rd_mux = ie_q;
    if (reg_addr == AW'(A_PD))    rd_mux = pd_q;
    if (reg_addr == AW'(A_PNORM)) rd_mux = 32'(per_norm);
    if (reg_addr == AW'(A_PHOT))  rd_mux = 32'(per_hot);
    if (reg_addr == AW'(A_DBHI))  rd_mux = 32'(db_hi);
    if (reg_addr == AW'(A_DBSH))  rd_mux = 32'(db_sh);
    for (int c = 0; c < NCH; c++) begin
      if (reg_addr == AW'(A_DATA + c)) rd_mux = 32'(data_w[c]);
      if (reg_addr == AW'(A_HI + c))   rd_mux = 32'(hi_thr[c]);
      if (reg_addr == AW'(A_SHUT + c)) rd_mux = 32'(sh_thr[c]);
      if (reg_addr == AW'(A_LO + c))   rd_mux = 32'(lo_thr[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  // ---------------- sequencer and channels ----------------
  thermo_seq #(.NCH(NCH), .PW(PW)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .auto_en  (ctrl_q[CB_AUTO]),
    .src_en   (ctrl_q[CB_SRC +: NCH]),
    .hot_any  (|hot),
    .per_norm (per_norm),
    .per_hot  (per_hot),
    .adc_done (adc_done),
    .adc_start(adc_start),
    .adc_sel  (adc_sel),
    .samp_vld (samp_vld),
    .samp_ch  (samp_ch)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    thermo_chan #(.DW(DW), .DBW(DBW)) u_ch (
      .clk   (clk),
      .rst   (rst),
      .clr   (!ctrl_q[CB_AUTO]),
      .samp  (samp_vld && (samp_ch == CHW'(g))),
      .code  (adc_code),
      .hi_thr(hi_thr[g]),
      .sh_thr(sh_thr[g]),
      .lo_thr(lo_thr[g]),
      .lo_en (ctrl_q[CB_LO + g]),
      .db_hi (db_hi),
      .db_sh (db_sh),
      .data_q(data_w[g]),
      .hi_evt(hi_evt[g]),
      .sh_evt(sh_evt[g]),
      .lo_evt(lo_evt[g]),
      .hot   (hot[g])
    );
  end

  // ---------------- pending and outputs ----------------
  always_comb begin
    pd_set = '0;
    pd_set[PB_EOC] = eoc_evt;
    for (int c = 0; c < NCH; c++) begin
      pd_set[PB_HI + c]   = hi_evt[c];
      pd_set[PB_SHUT + c] = sh_evt[c];
      pd_set[PB_LO + c]   = lo_evt[c];
    end
    pd_clr = (reg_wr && reg_addr == AW'(A_PD)) ? reg_wdata : '0;
  end

  assign gpio_act = |(pd_q[PB_SHUT +: NCH] & ie_q[PB_SHUT +: NCH]);

  always_ff @(posedge clk) begin
    if (rst) begin
      eoc_evt  <= 1'b0;
      pd_q     <= '0;
      irq      <= 1'b0;
      shut_rst <= 1'b0;
      shut_pin <= 1'b1;
    end else begin
      eoc_evt  <= samp_vld;
      pd_q     <= (pd_q & ~pd_clr) | pd_set;
      irq      <= |(pd_q & ie_q & IRQ_M);
      shut_rst <= |(pd_q[PB_SHUT +: NCH] & ie_q[PB_RST +: NCH]);
      shut_pin <= ctrl_q[CB_POL] ? gpio_act : !gpio_act;
    end
  end

endmodule

// File: rtl/thermo_watch_chk.sv
module thermo_watch_chk #(
  parameter int NCH = 2,
  parameter int AW  = 4,
  parameter int A_PD = 2,
  localparam int CHW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst,
  input logic           adc_start,
  input logic [CHW-1:0] adc_sel,
  input logic           auto_en,
  input logic [NCH-1:0] src_en,
  input logic           samp_vld,
  input logic [31:0]    pd_q,
  input logic           reg_wr,
  input logic [AW-1:0]  reg_addr,
  input logic [31:0]    reg_wdata
);

  logic [NCH-1:0] src_d;
  always_ff @(posedge clk) src_d <= src_en;

  // R3: start is a single-cycle pulse
  p_start_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    adc_start |=> !adc_start);

  // R3: only enabled sources are converted
  p_src_enabled_r3: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> src_d[adc_sel]);

  // R2: no start while auto mode is off
  p_auto_off_r2: assert property (@(posedge clk) disable iff (rst)
    !auto_en |=> !adc_start);

  // R8: every accepted conversion ends in a pending end-of-conversion bit
  p_eoc_r8: assert property (@(posedge clk) disable iff (rst)
    samp_vld |-> ##2 pd_q[16]);

  for (genvar g = 0; g < NCH; g++) begin : g_latch
    // R6: shutdown pending holds until written with a one
    p_shut_latch_r6: assert property (@(posedge clk) disable iff (rst)
      (pd_q[4 + g] && !(reg_wr && reg_addr == AW'(A_PD) && reg_wdata[4 + g]))
      |=> pd_q[4 + g]);
  end

endmodule

bind thermo_watch thermo_watch_chk #(.NCH(NCH), .AW(AW), .A_PD(2)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .adc_start(adc_start),
  .adc_sel  (adc_sel),
  .auto_en  (ctrl_q[0]),
  .src_en   (ctrl_q[4 +: NCH]),
  .samp_vld (samp_vld),
  .pd_q     (pd_q),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata)
);

// File: tb/thermo_watch_test.sv
module thermo_watch_test;

  localparam int TCLK = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        adc_start;
  logic [0:0]  adc_sel;
  logic        adc_done = 1'b0;
  logic [11:0] adc_code = '0;
  logic        irq, shut_rst, shut_pin;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [11:0] code_ch [2];
  int          start_n = 0;
  int          done_n  = 0;
  int          chan_log [64];
  int          cyc = 0;
  int          t_prev = 0, t_last = 0;

  // bit layout: code0[25:14] code1[13:2] expected low-alarm pending[1:0]
  localparam logic [25:0] VEC [6] = '{
    {12'h150, 12'h600, 2'b01},
    {12'h200, 12'h201, 2'b01},
    {12'h201, 12'h200, 2'b10},
    {12'h7AB, 12'h0FF, 2'b10},
    {12'h000, 12'h000, 2'b11},
    {12'hABC, 12'h555, 2'b00}
  };

  thermo_watch uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .adc_start(adc_start),
    .adc_sel(adc_sel), .adc_done(adc_done), .adc_code(adc_code),
    .irq(irq), .shut_rst(shut_rst), .shut_pin(shut_pin)
  );

  always #(TCLK/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // converter model: result three cycles after the start pulse
  int  dly = 0;
  bit  busy = 0;
  int  cur = 0;
  always @(negedge clk) begin
    adc_done = 1'b0;
    if (adc_start) begin
      busy = 1; dly = 3; cur = int'(adc_sel);
      chan_log[start_n % 64] = cur;
      start_n++;
      t_prev = t_last; t_last = cyc;
    end else if (busy) begin
      dly--;
      if (dly == 0) begin
        busy = 0; adc_done = 1'b1; adc_code = code_ch[cur]; done_n++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a[3:0]; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a[3:0];
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic wait_done(input int n);
    int tgt;
    tgt = done_n + n;
    while (done_n < tgt) @(posedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int base;
    code_ch[0] = '0; code_ch[1] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset values
    chk("R1 irq", 32'(irq), 0);
    chk("R1 shut_rst", 32'(shut_rst), 0);
    chk("R1 shut_pin", 32'(shut_pin), 1);
    chk("R1 adc_start", 32'(adc_start), 0);
    rd(11, v); chk("R1 normal period", v, 1875);
    rd(12, v); chk("R1 hot period", v, 1875);
    rd(13, v); chk("R1 high debounce", v, 4);
    rd(14, v); chk("R1 shut debounce", v, 4);
    rd(5, v);  chk("R1 high thr", v, 32'hFFF);
    rd(8, v);  chk("R1 shut thr", v, 32'hFFF);
    rd(9, v);  chk("R1 low thr", v, 0);

    // R2: sources on, auto off, short period
    wr(11, 10); wr(12, 10);
    wr(0, 32'h30);
    repeat (100) @(negedge clk);
    chk("R2 no start with auto off", start_n, 0);

    // table walk: R3 order, R4 data, R7 low alarm, R8 eoc, R9 irq
    wr(11, 30); wr(12, 30);
    wr(9, 32'h200); wr(10, 32'h200);
    wr(1, 32'h1000);
    code_ch[0] = VEC[0][25:14]; code_ch[1] = VEC[0][13:2];
    base = start_n;
    wr(0, 32'h3031);
    for (int i = 0; i < 6; i++) begin
      code_ch[0] = VEC[i][25:14]; code_ch[1] = VEC[i][13:2];
      wr(2, 32'h1FFFF);
      wait_done(2);
      if (i == 0) begin
        chk("R3 first chan", chan_log[base % 64], 0);
        chk("R3 second chan", chan_log[(base + 1) % 64], 1);
      end
      rd(3, v); chk("R4 data0", v, 32'(VEC[i][25:14]));
      rd(4, v); chk("R4 data1", v, 32'(VEC[i][13:2]));
      rd(2, v);
      chk("R7 low pending", 32'(v[13:12]), 32'(VEC[i][1:0]));
      chk("R8 eoc pending", 32'(v[16]), 1);
      chk("R9 irq from low0", 32'(irq), 32'(VEC[i][0]));
    end

    // R4: only channel 1 enabled
    wr(0, 0);
    code_ch[0] = 12'h111; code_ch[1] = 12'h222;
    wr(0, 32'h21);
    wait_done(1);
    rd(3, v); chk("R4 data0 untouched", v, 32'hABC);
    rd(4, v); chk("R4 data1 updated", v, 32'h222);
    chk("R3 skipped disabled chan", chan_log[(start_n - 1) % 64], 1);

    // R5: high alarm debounce of three, boundary at threshold
    wr(0, 0);
    wr(5, 32'h300); wr(13, 3); wr(1, 32'h1); wr(2, 32'h1FFFF);
    code_ch[0] = 12'h350;
    wr(0, 32'h11);
    begin
      logic [11:0] seq_c [6];
      logic        seq_e [6];
      seq_c = '{12'h350, 12'h300, 12'h2FF, 12'h350, 12'h300, 12'h350};
      seq_e = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
      for (int i = 0; i < 6; i++) begin
        code_ch[0] = seq_c[i];
        wait_done(1);
        rd(2, v);
        chk("R5 high pending", 32'(v[0]), 32'(seq_e[i]));
      end
      chk("R9 irq from high0", 32'(irq), 1);
    end

    // R11: hot period while above the high threshold
    wr(11, 200); wr(12, 20);
    wait_done(3);
    chk("R11 hot gap short", 32'((t_last - t_prev) < 60), 1);
    code_ch[0] = 12'h100;
    wait_done(2);
    chk("R11 normal gap long", 32'((t_last - t_prev) > 150), 1);

    // R6 and R10: shutdown to reset controller, latched
    wr(0, 0);
    wr(11, 30); wr(12, 30); wr(5, 32'hFFF);
    wr(7, 32'h400); wr(14, 2); wr(1, 32'h100); wr(2, 32'h1FFFF);
    code_ch[0] = 12'h450;
    wr(0, 32'h11);
    wait_done(1);
    rd(2, v); chk("R6 shut after one", 32'(v[4]), 0);
    chk("R10 shut_rst idle", 32'(shut_rst), 0);
    wait_done(1);
    rd(2, v); chk("R6 shut after two", 32'(v[4]), 1);
    chk("R10 shut_rst set", 32'(shut_rst), 1);
    chk("R10 pin not routed", 32'(shut_pin), 1);
    code_ch[0] = 12'h100;
    wait_done(1);
    chk("R6 shut latched", 32'(shut_rst), 1);
    wr(2, 32'h10);
    repeat (3) @(negedge clk);
    chk("R9 shut cleared", 32'(shut_rst), 0);
    rd(2, v); chk("R9 pending cleared", 32'(v[4]), 0);

    // R10: pin route for channel 1, active high
    wr(0, 0);
    wr(8, 32'h400); wr(1, 32'h20);
    code_ch[1] = 12'h450;
    wr(0, 32'h121);
    repeat (3) @(negedge clk);
    chk("R10 pin inactive high pol", 32'(shut_pin), 0);
    wait_done(1);
    chk("R10 pin after one", 32'(shut_pin), 0);
    wait_done(1);
    chk("R10 pin active", 32'(shut_pin), 1);
    chk("R10 rst not routed", 32'(shut_rst), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule